// File: doc/BRIEF.md
# Select-and-OR Register Readback

This block gives a host read access to a bank of internal registers without building a cascade of multiplexer stages. The read address is decoded into a separate select line for each register. Each register then feeds its own small readout stage. On a clock edge, a readout stage either takes its register's value, when it is selected, or goes to zero, when it is not. The read data bus is the bitwise OR of every readout stage, so each output bit costs a single wide OR gate and nothing else.

The host presents an address together with a one-cycle read strobe. One clock later the chosen register's value is on the read data bus and the read-valid flag is high for that cycle. Strobes may come on back-to-back cycles. An address that names no register still returns a valid cycle, but its data is all zeros.

Top module: `orrb_readback`

## Requirements
- R1: `rd_valid` is high in exactly the cycle that follows a clock edge at which `rd_stb` was sampled high, and low in every other cycle.
- R2: After a strobe with `rd_addr` below `N_REGS`, `rd_data` equals the value that register field `rd_addr` of `regs_flat` (bits `rd_addr*DATA_W` upward) held at the strobe edge.
- R3: In the cycle after an edge with `rd_stb` low, `rd_data` is all zeros.
- R4: A strobe with `rd_addr` at or above `N_REGS` gives `rd_valid` high and `rd_data` all zeros in the next cycle.
- R5: While `rst` is high, and in the cycle after an edge where it was high, `rd_valid` is low and `rd_data` is all zeros.
- R6: At most one register is selected per cycle, so `rd_data` never mixes bits from two registers.
- R7: A change on `regs_flat` after the capture edge leaves `rd_data` unchanged for the rest of that valid cycle. Back-to-back strobes each return their own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | ADDR_W | Index of the register to read |
| rd_stb | input | 1 | Read request, sampled each edge |
| regs_flat | input | N_REGS*DATA_W | All register values, register k in bits k*DATA_W upward |
| rd_data | output | DATA_W | OR of all readout stages |
| rd_valid | output | 1 | High in the cycle that carries read data |

## Verification
The assertions assume the address and strobe are stable and known at every rising edge and that reset is held high from time zero for at least one edge. They also assume that `regs_flat` may change at any time, which is why the capture check compares against the value sampled at the edge. The stimulus drives all inputs on the falling edge. It mixes random in-range and out-of-range addresses with idle cycles, and it uses non-zero random register contents so that a wrongly combined pair of registers would show up in the data.

// File: rtl/orrb_pkg.sv
package orrb_pkg;
  // Address width that can index n entries, never less than one bit.
  function automatic int unsigned addr_bits(int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/orrb_addr_decode.sv
module orrb_addr_decode #(
  parameter int unsigned N_REGS = 12,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              stb,
  output logic [N_REGS-1:0] sel
);
  // One enable per register, like a bus-driver enable; unmatched address gives none.
  for (genvar i = 0; i < N_REGS; i++) begin : g_sel
    assign sel[i] = stb && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/orrb_capture_stage.sv
module orrb_capture_stage #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || !sel) q <= '0;
    else             q <= d;
  end

  a_r2_stage_captures: assert property (@(posedge clk) disable iff (rst)
    sel |=> q == $past(d));
  a_r3_stage_clears: assert property (@(posedge clk) disable iff (rst)
    !sel |=> q == '0);
endmodule

// File: rtl/orrb_or_tree.sv
module orrb_or_tree #(
  parameter int unsigned N_REGS = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic [N_REGS*DATA_W-1:0] stages,
  output logic [DATA_W-1:0]        y
);
  // Each output bit is one wide OR across the same bit of every stage.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [N_REGS-1:0] column;
    for (genvar r = 0; r < N_REGS; r++) begin : g_row
      assign column[r] = stages[r*DATA_W + b];
    end
    assign y[b] = |column;
  end
endmodule

// File: rtl/orrb_readback.sv
module orrb_readback #(
  parameter int unsigned N_REGS = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = orrb_pkg::addr_bits(N_REGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     rd_stb,
  input  logic [N_REGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid
);
  localparam int unsigned BUS_W = N_REGS * DATA_W;

  logic [N_REGS-1:0] sel;
  logic [BUS_W-1:0]  stage_bus;

  orrb_addr_decode #(.N_REGS(N_REGS), .ADDR_W(ADDR_W)) u_dec (
    .addr(rd_addr), .stb(rd_stb), .sel(sel)
  );

  for (genvar k = 0; k < N_REGS; k++) begin : g_stage
    orrb_capture_stage #(.DATA_W(DATA_W)) u_stage (
      .clk(clk), .rst(rst), .sel(sel[k]),
      .d(regs_flat[k*DATA_W +: DATA_W]),
      .q(stage_bus[k*DATA_W +: DATA_W])
    );
  end

  orrb_or_tree #(.N_REGS(N_REGS), .DATA_W(DATA_W)) u_or (
    .stages(stage_bus), .y(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_stb;
  end

  a_r1_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_valid);
  a_r1_no_valid_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rd_valid);
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> rd_data == '0);
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && int'(rd_addr) >= int'(N_REGS)) |=> (rd_valid && rd_data == '0));
  a_r5_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rd_valid && rd_data == '0));
  a_r6_single_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
endmodule

// File: tb/sim_orrb_readback.sv
`timescale 1ns/1ps
module sim_orrb_readback;
  localparam int unsigned N = 12;
  localparam int unsigned W = 16;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_stb = 1'b0;
  logic [N*W-1:0] regs_flat = '0;
  logic [W-1:0]  rd_data;
  logic          rd_valid;

  logic [W-1:0] ref_mem [N];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  orrb_readback #(.N_REGS(N), .DATA_W(W), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_stb(rd_stb),
    .regs_flat(regs_flat), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [W-1:0] expect_data(bit stb, int unsigned a);
    if (stb && a < N) return ref_mem[a];
    return '0;
  endfunction

  task automatic push_regs();
    for (int k = 0; k < N; k++) regs_flat[k*W +: W] = ref_mem[k];
  endtask

  task automatic randomize_regs();
    for (int k = 0; k < N; k++) ref_mem[k] = W'($urandom_range(1, (1 << W) - 1));
    push_regs();
  endtask

  task automatic check(string req, logic [W-1:0] got_d, logic [W-1:0] exp_d,
                       logic got_v, logic exp_v);
    checks++;
    if (got_d !== exp_d || got_v !== exp_v) begin
      errors++;
      $display("FAIL %s: data %h valid %b, expected data %h valid %b",
               req, got_d, got_v, exp_d, exp_v);
    end
  endtask

  // Called at a falling edge: drive, wait one cycle, check result.
  task automatic one_read(string req, bit stb, int unsigned a);
    logic [W-1:0] e;
    rd_stb  = stb;
    rd_addr = AW'(a);
    e = expect_data(stb, a);
    @(negedge clk);
    check(req, rd_data, e, rd_valid, stb);
  endtask

  initial begin
    void'($urandom(32'h1f3a_77c1));
    randomize_regs();
    rd_stb = 1'b1;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    check("R5 during reset", rd_data, '0, rd_valid, 1'b0);
    rst = 1'b0;
    rd_stb = 1'b0;
    @(negedge clk);
    check("R5 after reset", rd_data, '0, rd_valid, 1'b0);

    // Directed: every register, back to back (R2, R7)
    for (int k = 0; k < N; k++) one_read("R2 R7 sweep", 1'b1, k);
    // Unmapped addresses (R4)
    for (int k = N; k < (1 << AW); k++) one_read("R4 unmapped", 1'b1, k);
    // Idle cycles return zero (R3, R1)
    one_read("R3 idle", 1'b0, 3);
    one_read("R1 R3 idle", 1'b0, 0);
    // Last and first register together in a burst (R6)
    one_read("R6 last", 1'b1, N - 1);
    one_read("R6 first", 1'b1, 0);

    // R7: registers change just after the capture edge
    rd_stb = 1'b1;
    rd_addr = AW'(5);
    begin
      logic [W-1:0] held;
      held = ref_mem[5];
      @(posedge clk);
      #1;
      randomize_regs();
      rd_stb = 1'b0;
      @(negedge clk);
      check("R7 hold after change", rd_data, held, rd_valid, 1'b1);
    end

    // Random traffic (R1 R2 R3 R4 R6)
    for (int i = 0; i < 400; i++) begin
      bit s;
      int unsigned a;
      if (i % 37 == 0) randomize_regs();
      s = ($urandom_range(0, 3) != 0);
      a = $urandom_range(0, (1 << AW) - 1);
      one_read("R1 R2 R3 R4 R6 random", s, a);
    end

    // Reset in mid-stream (R5)
    rd_stb = 1'b1;
    rd_addr = AW'(2);
    rst = 1'b1;
    @(negedge clk);
    check("R5 mid reset", rd_data, '0, rd_valid, 1'b0);
    rst = 1'b0;
    one_read("R2 after reset", 1'b1, 2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule